// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Per-CPU Mask

This block is the selection stage of a multi-CPU interrupt controller. It stores enable and pending state for every interrupt, separately for each CPU. For each CPU it looks at the interrupts that are both enabled and pending for that CPU and finds the most urgent one. A lower priority value means a more urgent interrupt. The winner is then tested against two thresholds: the CPU's priority mask and the CPU's running priority. The block drives, for each CPU, a pending interrupt ID and an interrupt request line, both registered.

Software reaches the state through one byte-wide write port. A set-enable or set-pending write covers eight consecutive interrupts. Each set bit acts on its own interrupt. For a shared interrupt, a set-pending bit follows the target mask of that interrupt. Interrupts numbered below the private boundary (32 by default) are banked per CPU, so a write only touches the copy of the CPU that issued it. The same port also loads a CPU's priority mask. The per-interrupt priorities, the per-interrupt target masks and the per-CPU running priorities are inputs owned by the surrounding controller.

Top module: `irq_prio_arbiter`

## Requirements
- R1: For each CPU, the candidate set is every interrupt that is both enabled and pending for that CPU. The selected interrupt is the candidate with the numerically smallest 8-bit priority.
- R2: When several candidates share the smallest priority, the one with the lowest interrupt ID is selected.
- R3: The selected interrupt is forwarded only when its priority is strictly less than the CPU's 8-bit priority mask. A forwarded interrupt appears on `pend_id`. When nothing is forwarded, `pend_id` is 1023 and `irq_req` is 0.
- R4: `irq_req` for a CPU is 1 only when an interrupt is forwarded and its priority is also strictly less than that CPU's 9-bit running priority. The running priority 0x100 means idle and lets every forwarded priority through.
- R5: A CPU with no candidate shows `pend_id` = 1023 and `irq_req` = 0.
- R6: Reset clears all enable and pending state, drives `pend_id` to 1023 and `irq_req` to 0, and sets every priority mask to 0x00, which blocks everything. With `LEGACY_MASK` = 1 the masks reset to 0xF0 instead.
- R7: A write with `wr_sel` = 0 is set-enable. Bit b of `wr_data` with `wr_idx` = k enables interrupt 8k+b. Zero bits change nothing. Bits that map to IDs at or above `NUM_IRQ` are ignored. A shared interrupt is enabled for all CPUs.
- R8: A write with `wr_sel` = 1 is set-pending. It uses the same bit mapping as set-enable. A shared interrupt becomes pending for exactly the CPUs set in its own target mask (`target_in` bit ID*NUM_CPU+c for CPU c).
- R9: For interrupts below `PRIV_IRQS`, a set-enable or set-pending write affects only the CPU given by `wr_cpu`. The target mask is not used for them.
- R10: A write with `wr_sel` = 2 loads `wr_data` into the priority mask of CPU `wr_cpu`. A write with `wr_sel` = 3 has no effect.
- R11: The outputs are registered. A state change made by a write at clock edge k appears on the outputs after edge k+1. A change of `prio_in` or `run_prio` appears after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prio_in | input | NUM_IRQ*8 | Priority of interrupt i in bits [8i+7:8i] |
| target_in | input | NUM_IRQ*NUM_CPU | Target mask; bit i*NUM_CPU+c targets CPU c |
| run_prio | input | NUM_CPU*9 | Running priority of CPU c in bits [9c+8:9c] |
| wr_en | input | 1 | Write strobe |
| wr_cpu | input | CPU_W | CPU performing the write |
| wr_sel | input | 2 | 0 set-enable, 1 set-pending, 2 priority mask, 3 none |
| wr_idx | input | BYTE_W | Byte index; covers interrupts 8*wr_idx..8*wr_idx+7 |
| wr_data | input | 8 | Write data |
| pend_id | output | NUM_CPU*10 | Forwarded interrupt ID of CPU c in bits [10c+9:10c] |
| irq_req | output | NUM_CPU | Interrupt request per CPU |

## Verification
The hardest case to reach is a banked private interrupt that one CPU has made pending while the other CPU's copy of the same ID stays clear. This can only happen through the write port, with `wr_cpu` set to one CPU, and only the other CPU's outputs show that the other copy was left alone. The stimulus enables the private byte from both CPUs, marks a private bit pending from just one of them, and then compares both CPUs' outputs. Strict-comparison boundaries are reached by loading masks and running priorities that equal the winning priority exactly, and by a sweep of priority patterns full of ties.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int unsigned PRIO_W  = 8;
   localparam int unsigned RUN_W   = 9;
   localparam int unsigned ID_W    = 10;
   localparam logic [9:0]  ID_NONE = 10'd1023;

   typedef enum logic [1:0] {
      WR_SET_EN   = 2'd0,
      WR_SET_PEND = 2'd1,
      WR_PMASK    = 2'd2,
      WR_NONE     = 2'd3
   } wr_kind_e;
endpackage

// File: rtl/irq_pend_state.sv
module irq_pend_state
   import irq_arb_pkg::*;
#(
   parameter int unsigned NUM_CPU   = 4,
   parameter int unsigned NUM_IRQ   = 64,
   parameter int unsigned PRIV_IRQS = 32,
   parameter int unsigned CPU_W     = 2,
   parameter int unsigned BYTE_W    = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_IRQ*NUM_CPU-1:0] target_in,
   input  logic                       wr_en,
   input  logic [CPU_W-1:0]           wr_cpu,
   input  logic [1:0]                 wr_sel,
   input  logic [BYTE_W-1:0]          wr_idx,
   input  logic [7:0]                 wr_data,
   output logic [NUM_IRQ*NUM_CPU-1:0] en_q,
   output logic [NUM_IRQ*NUM_CPU-1:0] pend_q
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      localparam logic [BYTE_W-1:0] BYTE_IDX = BYTE_W'(i / 8);
      localparam int unsigned       BIT_POS  = i % 8;
      logic hit;
      assign hit = wr_en && (wr_idx == BYTE_IDX) && wr_data[BIT_POS];

      for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
         localparam int unsigned K = i * NUM_CPU + c;
         logic en_scope, pend_scope;

         if (i < PRIV_IRQS) begin : g_priv
            // banked: only the writing CPU's copy
            assign en_scope   = (wr_cpu == CPU_W'(c));
            assign pend_scope = (wr_cpu == CPU_W'(c));

            AST_PRIV_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_en && wr_sel == WR_SET_PEND && wr_cpu != CPU_W'(c))
               |=> $stable(pend_q[K])); // R9
         end else begin : g_shared
            assign en_scope   = 1'b1;
            assign pend_scope = target_in[K];
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_q[K]   <= 1'b0;
               pend_q[K] <= 1'b0;
            end else begin
               if (hit && wr_sel == WR_SET_EN && en_scope)     en_q[K]   <= 1'b1;
               if (hit && wr_sel == WR_SET_PEND && pend_scope) pend_q[K] <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_arb_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 64
) (
   input  logic [NUM_IRQ-1:0]        cand,
   input  logic [NUM_IRQ*PRIO_W-1:0] prio_in,
   output logic                      found,
   output logic [PRIO_W-1:0]         best_prio,
   output logic [ID_W-1:0]           best_id
);
   logic [RUN_W-1:0] best;

   // strict compare keeps the earliest (lowest) ID on ties
   always_comb begin
      best    = 9'h100;
      best_id = ID_NONE;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (cand[i] && ({1'b0, prio_in[i*PRIO_W +: PRIO_W]} < best)) begin
            best    = {1'b0, prio_in[i*PRIO_W +: PRIO_W]};
            best_id = ID_W'(i);
         end
      end
      found     = !best[RUN_W-1];
      best_prio = best[PRIO_W-1:0];
   end
endmodule

// File: rtl/irq_cpu_gate.sv
module irq_cpu_gate
   import irq_arb_pkg::*;
#(
   parameter bit LEGACY_MASK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              found,
   input  logic [PRIO_W-1:0] best_prio,
   input  logic [ID_W-1:0]   best_id,
   input  logic [RUN_W-1:0]  run_prio,
   input  logic              pm_we,
   input  logic [PRIO_W-1:0] pm_data,
   output logic [ID_W-1:0]   pend_id,
   output logic              irq_req
);
   logic [PRIO_W-1:0] pm_rst;
   logic [PRIO_W-1:0] pmask;
   logic              fwd;

   if (LEGACY_MASK) begin : g_legacy
      assign pm_rst = 8'hF0;
   end else begin : g_modern
      assign pm_rst = 8'h00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     pmask <= pm_rst;
      else if (pm_we) pmask <= pm_data;
   end

   assign fwd = found && (best_prio < pmask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_id <= ID_NONE;
         irq_req <= 1'b0;
      end else begin
         pend_id <= fwd ? best_id : ID_NONE;
         irq_req <= fwd && ({1'b0, best_prio} < run_prio);
      end
   end

   AST_MASK_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_id != ID_NONE) |-> ($past(best_prio) < $past(pmask))); // R3
   AST_RUN_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ({1'b0, $past(best_prio)} < $past(run_prio))); // R4
   AST_REQ_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (pend_id != ID_NONE)); // R4
   AST_NO_CAND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(found) |-> (pend_id == ID_NONE && !irq_req)); // R5
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irq_arb_pkg::*;
#(
   parameter int unsigned NUM_CPU     = 4,
   parameter int unsigned NUM_IRQ     = 64,
   parameter int unsigned PRIV_IRQS   = 32,
   parameter bit          LEGACY_MASK = 1'b0,
   localparam int unsigned CPU_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   localparam int unsigned NUM_BYTES  = (NUM_IRQ + 7) / 8,
   localparam int unsigned BYTE_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_IRQ*8-1:0]       prio_in,
   input  logic [NUM_IRQ*NUM_CPU-1:0] target_in,
   input  logic [NUM_CPU*9-1:0]       run_prio,
   input  logic                       wr_en,
   input  logic [CPU_W-1:0]           wr_cpu,
   input  logic [1:0]                 wr_sel,
   input  logic [BYTE_W-1:0]          wr_idx,
   input  logic [7:0]                 wr_data,
   output logic [NUM_CPU*10-1:0]      pend_id,
   output logic [NUM_CPU-1:0]         irq_req
);
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must lie in 1..8");
   end
   if (NUM_IRQ < 1 || NUM_IRQ > 1020) begin : g_bad_irq
      $error("NUM_IRQ must lie in 1..1020");
   end
   if (PRIV_IRQS > NUM_IRQ) begin : g_bad_priv
      $error("PRIV_IRQS must not exceed NUM_IRQ");
   end

   logic [NUM_IRQ*NUM_CPU-1:0] en_q, pend_q;

   irq_pend_state #(
      .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .PRIV_IRQS(PRIV_IRQS),
      .CPU_W(CPU_W), .BYTE_W(BYTE_W)
   ) u_state (
      .clk(clk), .rst_n(rst_n), .target_in(target_in),
      .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_sel(wr_sel),
      .wr_idx(wr_idx), .wr_data(wr_data),
      .en_q(en_q), .pend_q(pend_q)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [NUM_IRQ-1:0] cand;
      logic               found;
      logic [PRIO_W-1:0]  best_prio;
      logic [ID_W-1:0]    best_id;
      logic               pm_we;

      for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cand
         assign cand[i] = en_q[i*NUM_CPU + c] & pend_q[i*NUM_CPU + c];
      end

      assign pm_we = wr_en && (wr_sel == WR_PMASK) && (wr_cpu == CPU_W'(c));

      irq_prio_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
         .cand(cand), .prio_in(prio_in),
         .found(found), .best_prio(best_prio), .best_id(best_id)
      );

      irq_cpu_gate #(.LEGACY_MASK(LEGACY_MASK)) u_gate (
         .clk(clk), .rst_n(rst_n),
         .found(found), .best_prio(best_prio), .best_id(best_id),
         .run_prio(run_prio[c*RUN_W +: RUN_W]),
         .pm_we(pm_we), .pm_data(wr_data),
         .pend_id(pend_id[c*ID_W +: ID_W]), .irq_req(irq_req[c])
      );
   end
endmodule

// File: tb/irq_prio_arbiter_tb.sv
module irq_prio_arbiter_tb;
   localparam int NC    = 2;
   localparam int NI    = 40;
   localparam int NPRIV = 32;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NI*8-1:0]  prio_flat;
   logic [NI*NC-1:0] tgt_flat;
   logic [NC*9-1:0]  run_flat;
   logic             wr_en = 1'b0;
   logic [0:0]       wr_cpu = '0;
   logic [1:0]       wr_sel = '0;
   logic [2:0]       wr_idx = '0;
   logic [7:0]       wr_data = '0;
   logic [NC*10-1:0] pend_id, leg_id;
   logic [NC-1:0]    irq_req, leg_req;

   logic [7:0] prio_a [NI];
   logic [1:0] tgt_a  [NI];
   logic [8:0] run_a  [NC];
   bit         en_m   [NI][NC];
   bit         pd_m   [NI][NC];
   logic [7:0] pm_m   [NC];

   int checks = 0;
   int fails  = 0;

   always #(CLK_P/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < NI; i++) begin
         prio_flat[i*8 +: 8] = prio_a[i];
         for (int c = 0; c < NC; c++) tgt_flat[i*NC + c] = tgt_a[i][c];
      end
      for (int c = 0; c < NC; c++) run_flat[c*9 +: 9] = run_a[c];
   end

   irq_prio_arbiter #(.NUM_CPU(NC), .NUM_IRQ(NI), .PRIV_IRQS(NPRIV), .LEGACY_MASK(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .prio_in(prio_flat), .target_in(tgt_flat),
      .run_prio(run_flat), .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_sel(wr_sel),
      .wr_idx(wr_idx), .wr_data(wr_data), .pend_id(pend_id), .irq_req(irq_req));

   irq_prio_arbiter #(.NUM_CPU(NC), .NUM_IRQ(NI), .PRIV_IRQS(NPRIV), .LEGACY_MASK(1'b1)) u_leg (
      .clk(clk), .rst_n(rst_n), .prio_in(prio_flat), .target_in(tgt_flat),
      .run_prio(run_flat), .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_sel(wr_sel),
      .wr_idx(wr_idx), .wr_data(wr_data), .pend_id(leg_id), .irq_req(leg_req));

   // expected forwarded ID from the requirements (R1, R2, R3, R5)
   function automatic int exp_id(int c);
      int best = 256;
      int id = 1023;
      for (int i = 0; i < NI; i++)
         if (en_m[i][c] && pd_m[i][c] && int'(prio_a[i]) < best) begin
            best = int'(prio_a[i]);
            id = i;
         end
      if (id != 1023 && !(best < int'(pm_m[c]))) id = 1023;
      return id;
   endfunction

   function automatic bit exp_req(int c);
      int id = exp_id(c);
      if (id == 1023) return 1'b0;
      return int'(prio_a[id]) < int'(run_a[c]);
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(string tag);
      for (int c = 0; c < NC; c++) begin
         check(tag, int'(pend_id[c*10 +: 10]), exp_id(c));
         check(tag, int'(irq_req[c]), int'(exp_req(c)));
      end
   endtask

   task automatic settle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic model_write(int cpu, int sel, int idx, logic [7:0] d);
      if (sel == 2) pm_m[cpu] = d;
      else if (sel < 2)
         for (int b = 0; b < 8; b++) begin
            int n = idx * 8 + b;
            if (d[b] && n < NI)
               for (int c = 0; c < NC; c++) begin
                  bit hit = (n < NPRIV) ? (c == cpu) : (sel == 0 ? 1'b1 : tgt_a[n][c]);
                  if (hit && sel == 0) en_m[n][c] = 1'b1;
                  if (hit && sel == 1) pd_m[n][c] = 1'b1;
               end
         end
   endtask

   task automatic wr(int cpu, int sel, int idx, logic [7:0] d);
      wr_en = 1'b1; wr_cpu = 1'(cpu); wr_sel = 2'(sel); wr_idx = 3'(idx); wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      model_write(cpu, sel, idx, d);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; wr_en = 1'b0;
      for (int i = 0; i < NI; i++)
         for (int c = 0; c < NC; c++) begin en_m[i][c] = 0; pd_m[i][c] = 0; end
      for (int c = 0; c < NC; c++) pm_m[c] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_P * 150000);
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < NI; i++) begin prio_a[i] = 8'h40; tgt_a[i] = 2'b11; end
      for (int c = 0; c < NC; c++) run_a[c] = 9'h100;
      @(negedge clk);
      do_reset();
      settle();
      // R6: reset state, masks at 0 block all
      check_all("R6 reset");
      wr(0, 0, 4, 8'h02); wr(0, 1, 4, 8'h02);
      prio_a[33] = 8'hE0;
      settle();
      check_all("R6 mask zero blocks");
      check("R6 legacy mask F0 forwards", int'(leg_id[9:0]), 33);
      check("R6 legacy mask F0 cpu1", int'(leg_id[19:10]), 33);
      prio_a[33] = 8'hF0;
      settle();
      check("R6 legacy mask F0 strict", int'(leg_id[9:0]), 1023);

      // R2 / R1: ties and urgency
      do_reset();
      for (int i = 0; i < NI; i++) begin prio_a[i] = 8'h40; tgt_a[i] = 2'b11; end
      wr(0, 2, 0, 8'hFF); wr(1, 2, 0, 8'hFF);
      wr(0, 0, 4, 8'hFF); wr(0, 1, 4, 8'h28);
      settle();
      check_all("R2 tie lowest id");
      check("R2 tie id 35", int'(pend_id[9:0]), 35);
      check_all("R5 cpu1 R7 shared enable");
      prio_a[37] = 8'h20;
      settle();
      check("R1 lower value wins", int'(pend_id[9:0]), 37);
      check_all("R1");
      // R3 mask strictness
      wr(0, 2, 0, 8'h20);
      settle();
      check("R3 equal to mask blocked", int'(pend_id[9:0]), 1023);
      check_all("R3");
      // R11 timing: write at edge k, visible after k+1
      wr_en = 1'b1; wr_cpu = 1'b0; wr_sel = 2'd2; wr_idx = 3'd0; wr_data = 8'h21;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
      check("R11 old value one cycle", int'(pend_id[9:0]), 1023);
      model_write(0, 2, 0, 8'h21);
      settle();
      check("R11 new value after next edge", int'(pend_id[9:0]), 37);
      // R4 running priority strictness
      run_a[0] = 9'h020;
      settle();
      check("R4 run equal no request", int'(irq_req[0]), 0);
      check("R4 id still shown", int'(pend_id[9:0]), 37);
      run_a[0] = 9'h021;
      settle();
      check("R4 run above request", int'(irq_req[0]), 1);
      run_a[0] = 9'h100;
      settle();
      check_all("R4 idle run");
      // R10: sel 3 and out-of-range byte ignored
      wr(0, 3, 4, 8'hFF); wr(0, 1, 7, 8'hFF); wr(1, 0, 6, 8'hFF);
      settle();
      check_all("R10 R7 ignored writes");

      // R9 / R8: private banking and target masks
      do_reset();
      for (int i = 0; i < NI; i++) begin prio_a[i] = 8'h80; tgt_a[i] = 2'b11; end
      tgt_a[36] = 2'b01;
      wr(0, 2, 0, 8'hFF); wr(1, 2, 0, 8'hFF);
      wr(0, 0, 0, 8'hFF); wr(1, 0, 0, 8'hFF);
      wr(1, 1, 0, 8'h08);
      settle();
      check("R9 private cpu1 sees", int'(pend_id[19:10]), 3);
      check("R9 private cpu0 untouched", int'(pend_id[9:0]), 1023);
      check_all("R9");
      wr(1, 0, 4, 8'h10); wr(1, 1, 4, 8'h10);
      prio_a[36] = 8'h10;
      settle();
      check("R8 target cpu0", int'(pend_id[9:0]), 36);
      check("R8 not target cpu1", int'(pend_id[19:10]), 3);
      wr(0, 1, 0, 8'h00);
      settle();
      check_all("R7 zero bits no effect");

      // sweep of priorities, running priorities, masks and pending growth
      do_reset();
      for (int i = 0; i < NI; i++) tgt_a[i] = 2'((i % 3) + 1);
      wr(0, 0, 0, 8'hFF); wr(0, 0, 1, 8'hFF); wr(0, 0, 2, 8'hFF);
      wr(0, 0, 3, 8'hFF); wr(0, 0, 4, 8'hFF);
      wr(1, 0, 0, 8'hF0); wr(1, 0, 2, 8'hFF); wr(1, 0, 3, 8'h3C);
      for (int k = 0; k < 64; k++) begin
         logic [7:0] masks [6] = '{8'hFF, 8'h90, 8'h60, 8'h30, 8'h00, 8'hC1};
         logic [8:0] runs  [4] = '{9'h100, 9'h060, 9'h000, 9'h090};
         for (int i = 0; i < NI; i++) prio_a[i] = 8'(((i * 7 + k * 13) % 5) * 8'h30);
         for (int c = 0; c < NC; c++) run_a[c] = runs[(k + c) % 4];
         if (k % 4 == 0) wr(k % 2 == 0 ? 0 : 1, 2, 0, masks[(k / 4) % 6]);
         if (k % 4 == 1) wr(k % 2 == 0 ? 0 : 1, 2, 0, masks[(k / 4 + 2) % 6]);
         wr(k % 2, 1, k % 5, 8'(8'h01 << (k % 8)) | 8'(8'h80 >> (k % 3)));
         settle();
         check_all("R1 R2 R3 R4 R8 sweep");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule